// File: doc/BRIEF.md
# Memory Operation Slot Controller

This block carries a single load or store from the moment it is accepted until it has finished. A command arrives over a valid/ready port. The block then expands the command into a per-byte table. Each table entry records whether that byte is still outstanding, the byte address, and one byte of data. Scalar commands fill the table directly from the command. Vector commands wait for one update from a vector unit for each register group. Each update supplies a byte-enable mask and, for stores, the store bytes. Addressing is unit-stride: byte `i` of group `g` sits at `base + g*SLOT_BYTES + i`.

While any entry is outstanding, the block issues memory beats. Each beat is aligned to `BEAT_BYTES` and starts from the lowest-indexed outstanding entry. It also gathers every other outstanding entry that falls in the same aligned beat. Read data returns one cycle after the beat handshake. When the table is empty, the block finishes in one of three ways:
- A scalar or floating-point load is extended and delivered on its own register port.
- A vector result or store acknowledgement is handed back to the vector unit.
- A scalar or floating-point store returns straight to idle.

Back-pressure rules apply on the streaming ports. On the memory port, the block holds `mem_valid` and every request field steady until `mem_ready`. On the vector-result port, it holds `vout_valid` and its payload steady until `vout_ready`. On the command port and the vector-update port, a transfer happens on any cycle where valid and ready are both high. The source may present data at any time.

Top module: `mem_slot_ctrl`

## Requirements
- R1: `cmd_ready` is high only when the slot is idle, and each command handshake starts exactly one operation. While busy, the slot accepts no command.
- R2: A scalar command with size code 0 (byte), 1 (halfword) or 2 (word) activates table entries 0..n-1 for addresses A..A+n-1, where n is 1, 2 or 4. A store writes exactly those bytes, taking them little-endian from `cmd_wdata`.
- R3: Every memory beat has an address aligned to `BEAT_BYTES`. The beat contains the lowest-indexed outstanding entry and every outstanding entry in the same aligned beat. `mem_wmask` bit `k` enables byte lane `k`, which is the address modulo `BEAT_BYTES`, and is never zero on a valid beat.
- R4: Load data is taken from `mem_rdata` in the cycle after the beat handshake. The slot leaves transfer only after that data has been captured.
- R5: Scalar loads are sign-extended to 32 bits when `cmd_uns` is 0 and zero-extended when it is 1.
- R6: An integer load yields exactly one single-cycle `wb_valid` pulse, with `wb_rd` equal to `cmd_rd`. A floating-point load yields the same on the `fwb_*` port instead. The two ports never pulse together.
- R7: Scalar and floating-point stores produce no writeback pulse and return to idle after their last beat.
- R8: `vin_ready` is high only in the vector-update phase, and no memory beat is valid there. Mask bit `i` enables byte `i`. A masked-off byte is never accessed: stores leave memory unchanged there, and loads return zero in that lane.
- R9: `vout_valid`, `vout_data`, `vout_reg` and `vout_store` stay stable until `vout_ready`. `vout_store` is 1 for a store acknowledgement and 0 for load data.
- R10: A vector command processes `cmd_groups+1` register groups in order. Group `g` reports `vout_reg = cmd_rd + g`, then re-enters vector update. The slot returns to idle after the last group.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_wmask` hold their values.
- R12: After reset the slot is idle, with `cmd_ready` high and `mem_valid`, `vin_ready`, `wb_valid`, `fwb_valid` and `vout_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Slot idle, command taken |
| cmd_vec | input | 1 | Vector operation |
| cmd_store | input | 1 | Store (1) or load (0) |
| cmd_flt | input | 1 | Floating-point register target |
| cmd_size | input | 2 | Scalar size: 0 byte, 1 half, 2 word |
| cmd_uns | input | 1 | Zero-extend scalar load |
| cmd_groups | input | GW | Register groups minus one (vector) |
| cmd_addr | input | 32 | Base byte address |
| cmd_wdata | input | 32 | Scalar store data |
| cmd_rd | input | 5 | Destination / first vector register |
| cmd_pc | input | 32 | Instruction PC, forwarded with beats |
| vin_valid | input | 1 | Vector update offered |
| vin_ready | output | 1 | Vector update taken |
| vin_mask | input | SLOT_BYTES | Byte-enable mask |
| vin_data | input | 8*SLOT_BYTES | Vector store bytes |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory beat accepted |
| mem_write | output | 1 | Beat is a write |
| mem_addr | output | 32 | Aligned beat address |
| mem_wmask | output | BEAT_BYTES | Lane enables |
| mem_wdata | output | 8*BEAT_BYTES | Write data by lane |
| mem_pc | output | 32 | PC of the operation |
| mem_rdata | input | 8*BEAT_BYTES | Read data, cycle after handshake |
| wb_valid | output | 1 | Integer writeback pulse |
| wb_rd | output | 5 | Integer destination |
| wb_data | output | 32 | Extended load value |
| fwb_valid | output | 1 | Float writeback pulse |
| fwb_rd | output | 5 | Float destination |
| fwb_data | output | 32 | Extended load value |
| vout_valid | output | 1 | Vector result / ack offered |
| vout_ready | input | 1 | Vector result taken |
| vout_store | output | 1 | Store acknowledgement flag |
| vout_reg | output | 5 | Vector register of this group |
| vout_data | output | 8*SLOT_BYTES | Loaded bytes (zero where masked off) |

## Verification
The assertions watch several properties on every cycle:
- The ready signals are exclusive: command ready, update ready and memory valid never coincide.
- The memory request and vector result are held steady under back-pressure.
- Beats are aligned and have a non-empty lane mask.
- Writeback pulses last one cycle, and the integer and float ports never pulse together.

The bench's scenarios are needed for everything about values, measured against a byte-level memory model:
- how scalar bytes gather across a beat boundary at every offset;
- sign and zero extension;
- the count of writebacks per operation;
- masked-off bytes staying untouched;
- ordering and register numbering across repeated register groups.

// File: rtl/lsu_slot_pkg.sv
package lsu_slot_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_VUPD  = 2'd1,
    ST_XFER  = 2'd2,
    ST_WBACK = 2'd3
  } slot_state_e;

  typedef struct packed {
    logic       vec;
    logic       store;
    logic       flt;
    logic [1:0] size;
    logic       uns;
  } slot_op_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  function automatic int unsigned size_bytes(input logic [1:0] sz);
    return (sz == SZ_BYTE) ? 1 : (sz == SZ_HALF) ? 2 : 4;
  endfunction
endpackage

// File: rtl/slot_table.sv
module slot_table #(
  parameter int ENTRIES = 16,
  parameter int AW      = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fill_en,
  input  logic [ENTRIES-1:0]     fill_act,
  input  logic [AW-1:0]          fill_base,
  input  logic [8*ENTRIES-1:0]   fill_data,
  input  logic                   clr_en,
  input  logic [ENTRIES-1:0]     clr_mask,
  input  logic                   upd_en,
  input  logic [ENTRIES-1:0]     upd_mask,
  input  logic [8*ENTRIES-1:0]   upd_data,
  output logic [ENTRIES-1:0]     active,
  output logic [AW*ENTRIES-1:0]  addrs,
  output logic [8*ENTRIES-1:0]   data
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active[e]          <= 1'b0;
        addrs[e*AW +: AW]  <= '0;
        data[e*8 +: 8]     <= '0;
      end else if (fill_en) begin
        active[e]          <= fill_act[e];
        addrs[e*AW +: AW]  <= fill_base + AW'(e);
        data[e*8 +: 8]     <= fill_data[e*8 +: 8];
      end else begin
        if (clr_en && clr_mask[e]) active[e] <= 1'b0;
        if (upd_en && upd_mask[e]) data[e*8 +: 8] <= upd_data[e*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/beat_bundler.sv
module beat_bundler #(
  parameter int ENTRIES    = 16,
  parameter int AW         = 32,
  parameter int BEAT_BYTES = 16
) (
  input  logic [ENTRIES-1:0]    active,
  input  logic [AW*ENTRIES-1:0] addrs,
  output logic                  any_act,
  output logic [AW-1:0]         beat_addr,
  output logic [ENTRIES-1:0]    sel
);
  localparam int LB = $clog2(BEAT_BYTES);

  logic [AW-1:0] lead_addr;
  logic          found;

  always_comb begin
    found     = 1'b0;
    lead_addr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (active[i] && !found) begin
        found     = 1'b1;
        lead_addr = addrs[i*AW +: AW];
      end
    end
  end

  assign any_act   = found;
  assign beat_addr = {lead_addr[AW-1:LB], {LB{1'b0}}};

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      sel[i] = active[i] && (addrs[i*AW+LB +: AW-LB] == lead_addr[AW-1:LB]);
  end
endmodule

// File: rtl/mem_slot_ctrl.sv
module mem_slot_ctrl
  import lsu_slot_pkg::*;
#(
  parameter int SLOT_BYTES = 16,
  parameter int BEAT_BYTES = 16,
  parameter int MAX_GROUPS = 8,
  localparam int GW = $clog2(MAX_GROUPS),
  localparam int LN = $clog2(SLOT_BYTES),
  localparam int LB = $clog2(BEAT_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic                    cmd_vec,
  input  logic                    cmd_store,
  input  logic                    cmd_flt,
  input  logic [1:0]              cmd_size,
  input  logic                    cmd_uns,
  input  logic [GW-1:0]           cmd_groups,
  input  logic [31:0]             cmd_addr,
  input  logic [31:0]             cmd_wdata,
  input  logic [4:0]              cmd_rd,
  input  logic [31:0]             cmd_pc,
  input  logic                    vin_valid,
  output logic                    vin_ready,
  input  logic [SLOT_BYTES-1:0]   vin_mask,
  input  logic [8*SLOT_BYTES-1:0] vin_data,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic                    mem_write,
  output logic [31:0]             mem_addr,
  output logic [BEAT_BYTES-1:0]   mem_wmask,
  output logic [8*BEAT_BYTES-1:0] mem_wdata,
  output logic [31:0]             mem_pc,
  input  logic [8*BEAT_BYTES-1:0] mem_rdata,
  output logic                    wb_valid,
  output logic [4:0]              wb_rd,
  output logic [31:0]             wb_data,
  output logic                    fwb_valid,
  output logic [4:0]              fwb_rd,
  output logic [31:0]             fwb_data,
  output logic                    vout_valid,
  input  logic                    vout_ready,
  output logic                    vout_store,
  output logic [4:0]              vout_reg,
  output logic [8*SLOT_BYTES-1:0] vout_data
);
  localparam int AW = 32;

  slot_state_e     state_q;
  slot_op_t        op_q;
  logic [4:0]      rd_q;
  logic [31:0]     pc_q;
  logic [31:0]     base_q;
  logic [GW-1:0]   groups_q;
  logic [GW-1:0]   group_q;
  logic            pend_q;
  logic [SLOT_BYTES-1:0] rsel_q;

  logic [SLOT_BYTES-1:0]    act;
  logic [AW*SLOT_BYTES-1:0] addrs;
  logic [8*SLOT_BYTES-1:0]  tdata;
  logic                     any_act;
  logic [AW-1:0]            beat_addr;
  logic [SLOT_BYTES-1:0]    sel;

  logic                     accept, vin_hs, mem_hs, fill_en;
  logic [SLOT_BYTES-1:0]    fill_act;
  logic [AW-1:0]            fill_base;
  logic [8*SLOT_BYTES-1:0]  fill_data;
  logic [8*SLOT_BYTES-1:0]  upd_data;
  logic [31:0]              ld_val;

  assign cmd_ready = (state_q == ST_IDLE);
  assign vin_ready = (state_q == ST_VUPD);
  assign accept    = cmd_valid && cmd_ready;
  assign vin_hs    = vin_valid && vin_ready;
  assign mem_valid = (state_q == ST_XFER) && any_act;
  assign mem_hs    = mem_valid && mem_ready;

  // Table fill: scalar from the command, vector from the update port.
  always_comb begin
    fill_en   = (accept && !cmd_vec) || vin_hs;
    fill_act  = '0;
    fill_data = '0;
    fill_base = cmd_addr;
    if (state_q == ST_IDLE) begin
      for (int i = 0; i < SLOT_BYTES; i++)
        fill_act[i] = (i < int'(size_bytes(cmd_size)));
      if (cmd_store) fill_data = (8*SLOT_BYTES)'(cmd_wdata);
    end else begin
      fill_act  = vin_mask;
      fill_base = base_q + (AW'(group_q) << LN);
      if (op_q.store) fill_data = vin_data;
    end
  end

  slot_table #(.ENTRIES(SLOT_BYTES), .AW(AW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_act(fill_act), .fill_base(fill_base), .fill_data(fill_data),
    .clr_en(mem_hs), .clr_mask(sel),
    .upd_en(pend_q), .upd_mask(rsel_q), .upd_data(upd_data),
    .active(act), .addrs(addrs), .data(tdata)
  );

  beat_bundler #(.ENTRIES(SLOT_BYTES), .AW(AW), .BEAT_BYTES(BEAT_BYTES)) u_bundle (
    .active(act), .addrs(addrs),
    .any_act(any_act), .beat_addr(beat_addr), .sel(sel)
  );

  // Lane mapping between table entries and beat bytes.
  always_comb begin
    mem_wmask = '0;
    mem_wdata = '0;
    upd_data  = '0;
    for (int i = 0; i < SLOT_BYTES; i++) begin
      if (sel[i]) begin
        mem_wmask[addrs[i*AW +: LB]] = 1'b1;
        mem_wdata[int'(addrs[i*AW +: LB])*8 +: 8] = tdata[i*8 +: 8];
      end
      upd_data[i*8 +: 8] = mem_rdata[int'(addrs[i*AW +: LB])*8 +: 8];
    end
  end

  assign mem_addr  = beat_addr;
  assign mem_write = op_q.store;
  assign mem_pc    = pc_q;

  // Scalar extension from the first table bytes.
  always_comb begin
    case (op_q.size)
      SZ_BYTE: ld_val = {{24{!op_q.uns && tdata[7]}}, tdata[7:0]};
      SZ_HALF: ld_val = {{16{!op_q.uns && tdata[15]}}, tdata[15:0]};
      default: ld_val = tdata[31:0];
    endcase
  end

  assign wb_valid   = (state_q == ST_WBACK) && !op_q.vec && !op_q.flt;
  assign fwb_valid  = (state_q == ST_WBACK) && !op_q.vec && op_q.flt;
  assign wb_rd      = rd_q;
  assign fwb_rd     = rd_q;
  assign wb_data    = ld_val;
  assign fwb_data   = ld_val;
  assign vout_valid = (state_q == ST_WBACK) && op_q.vec;
  assign vout_store = op_q.store;
  assign vout_reg   = rd_q + 5'(group_q);
  assign vout_data  = tdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= '0;
      rd_q     <= '0;
      pc_q     <= '0;
      base_q   <= '0;
      groups_q <= '0;
      group_q  <= '0;
      pend_q   <= 1'b0;
      rsel_q   <= '0;
    end else begin
      pend_q <= mem_hs && !op_q.store;
      if (mem_hs) rsel_q <= sel;
      case (state_q)
        ST_IDLE: if (accept) begin
          op_q     <= '{vec: cmd_vec, store: cmd_store, flt: cmd_flt,
                        size: cmd_size, uns: cmd_uns};
          rd_q     <= cmd_rd;
          pc_q     <= cmd_pc;
          base_q   <= cmd_addr;
          groups_q <= cmd_groups;
          group_q  <= '0;
          state_q  <= cmd_vec ? ST_VUPD : ST_XFER;
        end
        ST_VUPD: if (vin_hs) state_q <= ST_XFER;
        ST_XFER: if (!any_act && !pend_q)
          state_q <= (op_q.store && !op_q.vec) ? ST_IDLE : ST_WBACK;
        default: begin
          if (!op_q.vec) state_q <= ST_IDLE;
          else if (vout_ready) begin
            if (group_q == groups_q) state_q <= ST_IDLE;
            else begin
              group_q <= group_q + 1'b1;
              state_q <= ST_VUPD;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/slot_ctrl_chk.sv
module slot_ctrl_chk #(
  parameter int SLOT_BYTES = 16,
  parameter int BEAT_BYTES = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_ready,
  input logic                    vin_ready,
  input logic                    mem_valid,
  input logic                    mem_ready,
  input logic [31:0]             mem_addr,
  input logic [BEAT_BYTES-1:0]   mem_wmask,
  input logic                    wb_valid,
  input logic                    fwb_valid,
  input logic                    vout_valid,
  input logic                    vout_ready,
  input logic [8*SLOT_BYTES-1:0] vout_data,
  input logic [4:0]              vout_reg
);
  localparam int LB = $clog2(BEAT_BYTES);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mem_valid && !vin_ready && !vout_valid)); // R1
  AST_BEAT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[LB-1:0] == '0 && mem_wmask != '0)); // R3
  AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid || fwb_valid) |=> (!wb_valid && !fwb_valid)); // R6
  AST_WB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid && fwb_valid)); // R6
  AST_VUPD_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    vin_ready |-> !mem_valid); // R8
  AST_VOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vout_valid && !vout_ready) |=> (vout_valid && $stable(vout_data) && $stable(vout_reg))); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wmask))); // R11
endmodule

bind mem_slot_ctrl slot_ctrl_chk #(.SLOT_BYTES(SLOT_BYTES), .BEAT_BYTES(BEAT_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .vin_ready(vin_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wmask(mem_wmask),
  .wb_valid(wb_valid), .fwb_valid(fwb_valid), .vout_valid(vout_valid),
  .vout_ready(vout_ready), .vout_data(vout_data), .vout_reg(vout_reg)
);

// File: tb/tb_mem_slot_ctrl.sv
`timescale 1ns/1ps
module tb_mem_slot_ctrl;
  localparam int SB = 16;
  localparam int BB = 16;
  localparam int GW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cmd_valid = 0, cmd_vec = 0, cmd_store = 0, cmd_flt = 0, cmd_uns = 0;
  logic [1:0] cmd_size = 0;
  logic [GW-1:0] cmd_groups = 0;
  logic [31:0] cmd_addr = 0, cmd_wdata = 0, cmd_pc = 0;
  logic [4:0] cmd_rd = 0;
  logic cmd_ready;
  logic vin_valid = 0, vin_ready;
  logic [SB-1:0] vin_mask = 0;
  logic [8*SB-1:0] vin_data = 0;
  logic mem_valid, mem_write, mem_ready = 0;
  logic [31:0] mem_addr, mem_pc;
  logic [BB-1:0] mem_wmask;
  logic [8*BB-1:0] mem_wdata;
  logic [8*BB-1:0] mem_rdata = 0;
  logic wb_valid, fwb_valid, vout_valid, vout_store, vout_ready = 0;
  logic [4:0] wb_rd, fwb_rd, vout_reg;
  logic [31:0] wb_data, fwb_data;
  logic [8*SB-1:0] vout_data;

  mem_slot_ctrl #(.SLOT_BYTES(SB), .BEAT_BYTES(BB), .MAX_GROUPS(8)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_vec(cmd_vec), .cmd_store(cmd_store), .cmd_flt(cmd_flt), .cmd_size(cmd_size),
    .cmd_uns(cmd_uns), .cmd_groups(cmd_groups), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_rd(cmd_rd), .cmd_pc(cmd_pc), .vin_valid(vin_valid), .vin_ready(vin_ready),
    .vin_mask(vin_mask), .vin_data(vin_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wmask(mem_wmask), .mem_wdata(mem_wdata),
    .mem_pc(mem_pc), .mem_rdata(mem_rdata), .wb_valid(wb_valid), .wb_rd(wb_rd),
    .wb_data(wb_data), .fwb_valid(fwb_valid), .fwb_rd(fwb_rd), .fwb_data(fwb_data),
    .vout_valid(vout_valid), .vout_ready(vout_ready), .vout_store(vout_store),
    .vout_reg(vout_reg), .vout_data(vout_data)
  );

  logic [7:0] mem [512];
  logic [7:0] shadow [512];
  int nchk = 0, nfail = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: accept on handshake, read data valid one cycle later
  initial begin
    for (int k = 0; k < 512; k++) mem[k] = 8'(k * 37 + 11);
    forever begin
      @(posedge clk);
      if (mem_valid && mem_ready) begin
        for (int l = 0; l < BB; l++) begin
          if (mem_write) begin
            if (mem_wmask[l]) mem[9'(mem_addr + l)] <= mem_wdata[l*8 +: 8];
          end else
            mem_rdata[l*8 +: 8] <= mem[9'(mem_addr + l)];
        end
      end
    end
  end

  // back-pressure patterns
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mem_ready  = (cyc % 3) != 0;
      vout_ready = (cyc % 4) < 2;
    end
  end

  function automatic logic [SB-1:0] vmask(input int seed, input int g);
    return (seed == 0) ? '0 : SB'(seed * 40503 + g * 947);
  endfunction
  function automatic logic [7:0] vbyte(input int seed, input int g, input int i);
    return 8'(seed * 3 + g * 16 + i + 1);
  endfunction

  task automatic run_op(input bit vec, input bit st, input bit flt, input logic [1:0] sz,
                        input bit uns, input int grp, input int addr,
                        input logic [31:0] wd, input logic [4:0] rd, input int seed);
    int nwb, nfwb, nvo, g, n;
    logic [31:0] wbd, fwbd, expv;
    logic [4:0] wbr;
    bit vin_hs, hold_m, hold_v;
    logic [31:0] ha;
    logic [8*SB-1:0] hv;
    for (int k = 0; k < 512; k++) shadow[k] = mem[k];
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 idle ready", 64'(cmd_ready), 1);
    cmd_valid = 1; cmd_vec = vec; cmd_store = st; cmd_flt = flt; cmd_size = sz;
    cmd_uns = uns; cmd_groups = GW'(grp); cmd_addr = 32'(addr); cmd_wdata = wd;
    cmd_rd = rd; cmd_pc = 32'h100 + 32'(addr);
    g = 0; vin_valid = vec; vin_mask = vmask(seed, 0);
    for (int i = 0; i < SB; i++) vin_data[i*8 +: 8] = vbyte(seed, 0, i);
    @(negedge clk);
    cmd_valid = 0;
    chk(cmd_ready == 1'b0, "R1 busy not ready", 64'(cmd_ready), 0);
    nwb = 0; nfwb = 0; nvo = 0; wbd = 0; fwbd = 0; wbr = 0; n = 0;
    hold_m = 0; hold_v = 0; ha = 0; hv = 0;
    while (!cmd_ready && n < 3000) begin
      if (hold_m) chk(mem_valid && mem_addr == ha, "R11 mem hold", 64'(mem_addr), 64'(ha));
      if (hold_v) chk(vout_valid && vout_data == hv, "R9 vout hold", 64'(vout_valid), 1);
      hold_m = mem_valid && !mem_ready; ha = mem_addr;
      hold_v = vout_valid && !vout_ready; hv = vout_data;
      if (wb_valid) begin nwb++; wbd = wb_data; wbr = wb_rd; end
      if (fwb_valid) begin nfwb++; fwbd = fwb_data; wbr = fwb_rd; end
      if (vout_valid && vout_ready) begin
        chk(vout_reg == 5'(rd + nvo), "R10 group register", 64'(vout_reg), 64'(rd + nvo));
        chk(vout_store == st, "R9 store flag", 64'(vout_store), 64'(st));
        if (!st) begin
          for (int i = 0; i < SB; i++) begin
            logic [7:0] e;
            e = vmask(seed, nvo)[i] ? shadow[9'(addr + nvo * SB + i)] : 8'h00;
            chk(vout_data[i*8 +: 8] == e, "R8 vector load lane",
                64'(vout_data[i*8 +: 8]), 64'(e));
          end
        end
        nvo++;
      end
      vin_hs = vin_valid && vin_ready;
      @(negedge clk);
      n++;
      if (vin_hs) begin
        g++;
        vin_mask = vmask(seed, g);
        for (int i = 0; i < SB; i++) vin_data[i*8 +: 8] = vbyte(seed, g, i);
      end
    end
    vin_valid = 0;
    @(negedge clk);
    if (vec) begin
      chk(nvo == grp + 1, "R10 group count", 64'(nvo), 64'(grp + 1));
      if (st)
        for (int gg = 0; gg <= grp; gg++)
          for (int i = 0; i < SB; i++) begin
            logic [7:0] e;
            int a;
            a = addr + gg * SB + i;
            e = vmask(seed, gg)[i] ? vbyte(seed, gg, i) : shadow[9'(a)];
            chk(mem[9'(a)] == e, "R8 vector store byte", 64'(mem[9'(a)]), 64'(e));
          end
    end else if (st) begin
      int nb;
      nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      chk(nwb == 0 && nfwb == 0, "R7 no writeback on store", 64'(nwb + nfwb), 0);
      for (int i = -1; i <= nb; i++) begin
        logic [7:0] e;
        e = (i >= 0 && i < nb) ? wd[i*8 +: 8] : shadow[9'(addr + i)];
        chk(mem[9'(addr + i)] == e, "R2 store bytes", 64'(mem[9'(addr + i)]), 64'(e));
      end
    end else begin
      logic [31:0] w;
      w = {shadow[9'(addr + 3)], shadow[9'(addr + 2)], shadow[9'(addr + 1)], shadow[9'(addr)]};
      case (sz)
        2'd0: expv = uns ? {24'd0, w[7:0]} : {{24{w[7]}}, w[7:0]};
        2'd1: expv = uns ? {16'd0, w[15:0]} : {{16{w[15]}}, w[15:0]};
        default: expv = w;
      endcase
      if (flt) begin
        chk(nfwb == 1 && nwb == 0, "R6 float pulse count", 64'(nfwb), 1);
        chk(fwbd == expv, "R5 R4 float load value", 64'(fwbd), 64'(expv));
      end else begin
        chk(nwb == 1 && nfwb == 0, "R6 int pulse count", 64'(nwb), 1);
        chk(wbd == expv, "R5 R4 load value", 64'(wbd), 64'(expv));
      end
      chk(wbr == rd, "R6 writeback register", 64'(wbr), 64'(rd));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready == 1, "R12 reset ready", 64'(cmd_ready), 1);
    chk(!mem_valid && !vin_ready, "R12 reset mem/vin", 64'({mem_valid, vin_ready}), 0);
    chk(!wb_valid && !fwb_valid && !vout_valid, "R12 reset outputs",
        64'({wb_valid, fwb_valid, vout_valid}), 0);
    // R3 R5: scalar loads, every size, extension mode and in-beat offset
    for (int sz = 0; sz < 3; sz++)
      for (int u = 0; u < 2; u++)
        for (int off = 0; off < 16; off++)
          run_op(0, 0, 0, 2'(sz), u[0], 0, 32 + off, 0, 5'(off + 1), 0);
    // R2 R3: scalar stores at every offset, including beat-crossing words
    for (int sz = 0; sz < 3; sz++)
      for (int off = 0; off < 16; off++)
        run_op(0, 1, 0, 2'(sz), 0, 0, 96 + off, 32'h80C1_F203 + 32'(off * 4099), 5'd3, 0);
    // R6 float loads and R7 float stores
    for (int off = 12; off < 16; off++) begin
      run_op(0, 0, 1, 2'd2, 0, 0, 160 + off, 0, 5'(20 + off - 12), 0);
      run_op(0, 1, 1, 2'd2, 0, 0, 176 + off, 32'hDEAD_0000 + 32'(off), 5'd1, 0);
    end
    // R8 R9 R10: vector loads and stores across groups, bases and masks
    for (int grp = 0; grp < 4; grp++)
      for (int st = 0; st < 2; st++)
        for (int b = 0; b < 3; b++)
          run_op(1, st[0], 0, 2'd0, 0, grp, 256 + b * 5, 0, 5'(8 + grp), st * 7 + b + grp * 13);
    // all-zero mask: no access, zero load lanes (R8)
    run_op(1, 0, 0, 2'd0, 0, 1, 300, 0, 5'd2, 0);
    run_op(1, 1, 0, 2'd0, 0, 1, 300, 0, 5'd2, 0);
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule